// File: doc/BRIEF.md
# Compressed 16-bit instruction decoder

This block classifies a single 16-bit compressed instruction word into one operation code and breaks out its register fields. It is purely combinational: a word presented on `instr_i` produces its operation code, an illegal flag and the register indices in the same cycle, ready for an issue or expansion stage to use. The decoder does not compute immediates, touch a register file or access memory. The one exception is the stack-relative wide add, where a zero immediate makes the word illegal, so that immediate is inspected.

Classification works down a tree of fields. The two low bits select a quadrant. The top three bits (funct3) split each quadrant into groups. A few groups need further sub-fields to tell their members apart: bits 11:10 and 6:5 in the arithmetic group, and bit 12 plus bits 6:2 or 11:2 in the register jump/move group. Floating-point load and store forms are recognised, but they get a dedicated "unsupported" code and are flagged illegal.

Each register field is reported in two ways: as a 5-bit index taken from the full-width field, and as a 3-bit short field together with its expansion to registers 8 to 15.

Top module: `c16_decoder`

## Requirements
- R1: A word whose bits [1:0] are 11 gives op_o = 0 (illegal) with illegal_o = 1.
- R2: For bits [1:0] = 00, funct3 (bits [15:13]) maps as follows: 000 gives op 1 (stack-relative wide add), 010 gives op 2 (load word), 110 gives op 3 (store word) and 100 gives op 0. The codes 001, 011, 101 and 111 give op 27 (floating-point memory, unsupported).
- R3: Op 1 with bits [12:5] all zero sets illegal_o = 1 and keeps op 1. The all-zero word is therefore always illegal.
- R4: For bits [1:0] = 01, funct3 maps as follows: 000 gives op 4 (add immediate), 001 gives op 5 (call), 010 gives op 6 (load immediate), 101 gives op 16 (jump), 110 gives op 17 (branch if zero) and 111 gives op 18 (branch if not zero).
- R5: For bits [1:0] = 01 with funct3 011, an rd field (bits [11:7]) equal to 2 gives op 7 (stack adjust). Any other rd gives op 8 (upper immediate).
- R6: For bits [1:0] = 01 with funct3 100, bits [11:10] select the operation: 00 gives op 9 (logical right shift), 01 gives op 10 (arithmetic right shift) and 10 gives op 11 (and immediate). The value 11 hands the choice to bits [6:5]: 00 gives op 12 (sub), 01 gives op 13 (xor), 10 gives op 14 (or) and 11 gives op 15 (and).
- R7: For bits [1:0] = 10, funct3 maps as follows: 000 gives op 19 (left shift), 010 gives op 20 (stack load), 110 gives op 26 (stack store). The codes 001, 011, 101 and 111 give op 27.
- R8: For bits [1:0] = 10 with funct3 100 and bit 12 = 0, bits [6:2] = 0 give op 21 (register jump). Any other value gives op 22 (move).
- R9: For bits [1:0] = 10 with funct3 100 and bit 12 = 1, the checks are made in priority order. Bits [11:2] all zero give op 23 (breakpoint). Failing that, bits [6:2] = 0 give op 24 (register call). Otherwise the word gives op 25 (add).
- R10: illegal_o is 1 exactly when op_o is 0 or 27, or when R3 applies.
- R11: rd_o and rs1_o both equal bits [11:7], and rs2_o equals bits [6:2], for every word.
- R12: rs1s_o equals bits [9:7] and rs2s_o equals bits [4:2]. rs1s_x_o and rs2s_x_o equal the matching short field plus 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Compressed instruction word |
| op_o | output | 5 | Operation code (encoding in R1 to R9) |
| illegal_o | output | 1 | Word is illegal or unsupported |
| rd_o | output | 5 | Full destination field, bits 11:7 |
| rs1_o | output | 5 | Full first source field, bits 11:7 |
| rs2_o | output | 5 | Full second source field, bits 6:2 |
| rs1s_o | output | 3 | Short first source field, bits 9:7 |
| rs2s_o | output | 3 | Short second source field, bits 4:2 |
| rs1s_x_o | output | 5 | rs1s_o expanded to register 8 to 15 |
| rs2s_x_o | output | 5 | rs2s_o expanded to register 8 to 15 |

## Verification
The bench first applies a short directed list: the all-zero word, the breakpoint word, register jumps to x1 and a stack adjust with rd = 2. Together these show whether the priority chains and the zero-immediate rule hold at their exact boundaries. It then applies all 65,536 words and compares them against an arithmetic model written from the requirements. The sweep reaches every quadrant and funct3 pair, every value of every sub-field, and every rd value next to 2. As a result, a swapped table entry, a dropped priority step or a mis-sliced register field each shows up on specific words.

// File: rtl/c16_pkg.sv
package c16_pkg;

    localparam int INSN_W     = 16;
    localparam int REG_W      = 5;
    localparam int SHORT_W    = 3;
    localparam int OP_W       = 5;
    localparam int SHORT_BASE = 8;

    typedef enum logic [OP_W-1:0] {
        OP_BAD     = 5'd0,
        OP_SPADDW  = 5'd1,
        OP_LDW     = 5'd2,
        OP_STW     = 5'd3,
        OP_ADDIMM  = 5'd4,
        OP_CALL    = 5'd5,
        OP_LDIMM   = 5'd6,
        OP_SPADJ   = 5'd7,
        OP_UPIMM   = 5'd8,
        OP_SHR     = 5'd9,
        OP_SAR     = 5'd10,
        OP_ANDIMM  = 5'd11,
        OP_SUB     = 5'd12,
        OP_XOR     = 5'd13,
        OP_OR      = 5'd14,
        OP_AND     = 5'd15,
        OP_JUMP    = 5'd16,
        OP_BRZ     = 5'd17,
        OP_BRNZ    = 5'd18,
        OP_SHL     = 5'd19,
        OP_LDSP    = 5'd20,
        OP_JREG    = 5'd21,
        OP_MOVE    = 5'd22,
        OP_BRK     = 5'd23,
        OP_CALLREG = 5'd24,
        OP_ADD     = 5'd25,
        OP_STSP    = 5'd26,
        OP_FPMEM   = 5'd27
    } op_e;

    typedef struct packed {
        op_e  op;
        logic bad;
    } dec_t;

    // Build a decode result; unknown and unsupported codes carry the flag.
    function automatic dec_t mk_dec(op_e o);
        dec_t d;
        d.op  = o;
        d.bad = (o == OP_BAD) || (o == OP_FPMEM);
        return d;
    endfunction

    function automatic logic [REG_W-1:0] widen_short(logic [SHORT_W-1:0] s);
        return REG_W'(SHORT_BASE) + REG_W'(s);
    endfunction

endpackage

// File: rtl/c16_quad0_dec.sv
module c16_quad0_dec
    import c16_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    always_comb begin
        unique case (insn[15:13])
            3'b000: begin
                dec     = mk_dec(OP_SPADDW);
                // A zero scaled immediate is reserved.
                dec.bad = (insn[12:5] == '0);
            end
            3'b010:  dec = mk_dec(OP_LDW);
            3'b110:  dec = mk_dec(OP_STW);
            3'b100:  dec = mk_dec(OP_BAD);
            default: dec = mk_dec(OP_FPMEM);
        endcase
    end
endmodule

// File: rtl/c16_quad1_dec.sv
module c16_quad1_dec
    import c16_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    localparam logic [REG_W-1:0] SP_IDX = REG_W'(2);

    op_e alu_op;

    // Arithmetic group: two-level split on bits 11:10 then 6:5.
    always_comb begin
        unique case (insn[11:10])
            2'b00: alu_op = OP_SHR;
            2'b01: alu_op = OP_SAR;
            2'b10: alu_op = OP_ANDIMM;
            default: begin
                unique case (insn[6:5])
                    2'b00:   alu_op = OP_SUB;
                    2'b01:   alu_op = OP_XOR;
                    2'b10:   alu_op = OP_OR;
                    default: alu_op = OP_AND;
                endcase
            end
        endcase
    end

    always_comb begin
        unique case (insn[15:13])
            3'b000:  dec = mk_dec(OP_ADDIMM);
            3'b001:  dec = mk_dec(OP_CALL);
            3'b010:  dec = mk_dec(OP_LDIMM);
            3'b011:  dec = mk_dec((insn[11:7] == SP_IDX) ? OP_SPADJ : OP_UPIMM);
            3'b100:  dec = mk_dec(alu_op);
            3'b101:  dec = mk_dec(OP_JUMP);
            3'b110:  dec = mk_dec(OP_BRZ);
            default: dec = mk_dec(OP_BRNZ);
        endcase
    end
endmodule

// File: rtl/c16_quad2_dec.sv
module c16_quad2_dec
    import c16_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic src2_zero;
    logic low_all_zero;
    op_e  reg_op;

    assign src2_zero    = (insn[6:2] == '0);
    assign low_all_zero = (insn[11:2] == '0);

    // Register jump / move / add group; bit 12 splits, then priority chain.
    always_comb begin
        if (!insn[12]) begin
            reg_op = src2_zero ? OP_JREG : OP_MOVE;
        end else if (low_all_zero) begin
            reg_op = OP_BRK;
        end else if (src2_zero) begin
            reg_op = OP_CALLREG;
        end else begin
            reg_op = OP_ADD;
        end
    end

    always_comb begin
        unique case (insn[15:13])
            3'b000:  dec = mk_dec(OP_SHL);
            3'b010:  dec = mk_dec(OP_LDSP);
            3'b100:  dec = mk_dec(reg_op);
            3'b110:  dec = mk_dec(OP_STSP);
            default: dec = mk_dec(OP_FPMEM);
        endcase
    end
endmodule

// File: rtl/c16_short_reg.sv
module c16_short_reg
    import c16_pkg::*;
(
    input  logic [SHORT_W-1:0] short_idx,
    output logic [REG_W-1:0]   full_idx
);
    assign full_idx = widen_short(short_idx);
endmodule

// File: rtl/c16_decoder.sv
module c16_decoder
    import c16_pkg::*;
(
    input  logic [INSN_W-1:0]  instr_i,
    output logic [OP_W-1:0]    op_o,
    output logic               illegal_o,
    output logic [REG_W-1:0]   rd_o,
    output logic [REG_W-1:0]   rs1_o,
    output logic [REG_W-1:0]   rs2_o,
    output logic [SHORT_W-1:0] rs1s_o,
    output logic [SHORT_W-1:0] rs2s_o,
    output logic [REG_W-1:0]   rs1s_x_o,
    output logic [REG_W-1:0]   rs2s_x_o
);
    localparam int N_SHORT = 2;

    dec_t q0_dec, q1_dec, q2_dec, sel_dec;

    c16_quad0_dec u_q0 (.insn(instr_i), .dec(q0_dec));
    c16_quad1_dec u_q1 (.insn(instr_i), .dec(q1_dec));
    c16_quad2_dec u_q2 (.insn(instr_i), .dec(q2_dec));

    always_comb begin
        unique case (instr_i[1:0])
            2'b00:   sel_dec = q0_dec;
            2'b01:   sel_dec = q1_dec;
            2'b10:   sel_dec = q2_dec;
            default: sel_dec = mk_dec(OP_BAD);
        endcase
    end

    assign op_o      = sel_dec.op;
    assign illegal_o = sel_dec.bad;

    assign rd_o  = instr_i[11:7];
    assign rs1_o = instr_i[11:7];
    assign rs2_o = instr_i[6:2];

    logic [N_SHORT-1:0][SHORT_W-1:0] short_f;
    logic [N_SHORT-1:0][REG_W-1:0]   short_x;

    assign short_f[0] = instr_i[9:7];
    assign short_f[1] = instr_i[4:2];

    for (genvar g = 0; g < N_SHORT; g++) begin : g_short
        c16_short_reg u_sr (.short_idx(short_f[g]), .full_idx(short_x[g]));
    end

    assign rs1s_o   = short_f[0];
    assign rs2s_o   = short_f[1];
    assign rs1s_x_o = short_x[0];
    assign rs2s_x_o = short_x[1];
endmodule

// File: rtl/c16_decoder_chk.sv
module c16_decoder_chk
    import c16_pkg::*;
(
    input logic [INSN_W-1:0]  instr_i,
    input logic [OP_W-1:0]    op_o,
    input logic               illegal_o,
    input logic [SHORT_W-1:0] rs1s_o,
    input logic [REG_W-1:0]   rs1s_x_o,
    input logic [SHORT_W-1:0] rs2s_o,
    input logic [REG_W-1:0]   rs2s_x_o
);
    always_comb begin
        if (!$isunknown(instr_i)) begin
            if (instr_i[1:0] == 2'b11) begin
                a_r1_quad_reserved: assert (illegal_o && op_o == 5'd0);
            end
            if (instr_i == '0) begin
                a_r3_zero_word: assert (illegal_o);
            end
            if (op_o == 5'd0 || op_o == 5'd27) begin
                a_r10_bad_flagged: assert (illegal_o);
            end
            if (illegal_o) begin
                a_r10_flag_cause: assert (op_o == 5'd0 || op_o == 5'd27 || op_o == 5'd1);
            end
            if (op_o == 5'd23) begin
                a_r9_brk_fields: assert (instr_i[12] && instr_i[11:2] == '0);
            end
            if (op_o == 5'd21) begin
                a_r8_jreg_fields: assert (!instr_i[12] && instr_i[6:2] == '0);
            end
            a_r12_short1_range: assert (rs1s_x_o[4:3] == 2'b01 && rs1s_x_o[2:0] == rs1s_o);
            a_r12_short2_range: assert (rs2s_x_o[4:3] == 2'b01 && rs2s_x_o[2:0] == rs2s_o);
        end
    end
endmodule

bind c16_decoder c16_decoder_chk u_chk (
    .instr_i  (instr_i),
    .op_o     (op_o),
    .illegal_o(illegal_o),
    .rs1s_o   (rs1s_o),
    .rs1s_x_o (rs1s_x_o),
    .rs2s_o   (rs2s_o),
    .rs2s_x_o (rs2s_x_o)
);

// File: tb/c16_decoder_tb.sv
`timescale 1ns/1ps
module c16_decoder_tb;

    logic        clk = 1'b0;
    logic [15:0] instr_i = 16'h0000;
    logic [4:0]  op_o;
    logic        illegal_o;
    logic [4:0]  rd_o, rs1_o, rs2_o, rs1s_x_o, rs2s_x_o;
    logic [2:0]  rs1s_o, rs2s_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    c16_decoder u_dut (
        .instr_i  (instr_i),
        .op_o     (op_o),
        .illegal_o(illegal_o),
        .rd_o     (rd_o),
        .rs1_o    (rs1_o),
        .rs2_o    (rs2_o),
        .rs1s_o   (rs1s_o),
        .rs2s_o   (rs2s_o),
        .rs1s_x_o (rs1s_x_o),
        .rs2s_x_o (rs2s_x_o)
    );

    // Reference model from the requirements; tag names the deciding rule.
    function automatic void model(input logic [15:0] w, output int op,
                                  output bit bad, output string tag);
        int q  = int'(w[1:0]);
        int f3 = int'(w[15:13]);
        bad = 1'b0;
        if (q == 3) begin
            op = 0; tag = "R1";
        end else if (q == 0) begin
            tag = "R2";
            if (f3 % 2 == 1) op = 27;
            else if (f3 == 0) begin
                op = 1;
                if (int'(w[12:5]) == 0) begin bad = 1'b1; tag = "R3"; end
            end
            else if (f3 == 2) op = 2;
            else if (f3 == 6) op = 3;
            else op = 0;
        end else if (q == 1) begin
            tag = "R4";
            if (f3 == 3) begin
                tag = "R5";
                op = (int'(w[11:7]) == 2) ? 7 : 8;
            end else if (f3 == 4) begin
                tag = "R6";
                if (int'(w[11:10]) < 3) op = 9 + int'(w[11:10]);
                else op = 12 + int'(w[6:5]);
            end else if (f3 < 3) op = 4 + f3;
            else op = 16 + (f3 - 5);
        end else begin
            tag = "R7";
            if (f3 == 4) begin
                if (w[12] == 1'b0) begin
                    tag = "R8";
                    op = (int'(w[6:2]) == 0) ? 21 : 22;
                end else begin
                    tag = "R9";
                    if (int'(w[11:2]) == 0) op = 23;
                    else if (int'(w[6:2]) == 0) op = 24;
                    else op = 25;
                end
            end
            else if (f3 % 2 == 1) op = 27;
            else if (f3 == 0) op = 19;
            else if (f3 == 2) op = 20;
            else op = 26;
        end
        if (op == 0 || op == 27) bad = 1'b1;
    endfunction

    task automatic apply(input logic [15:0] w);
        int    e_op;
        bit    e_bad;
        string tag;
        @(posedge clk);
        instr_i = w;
        @(negedge clk);
        model(w, e_op, e_bad, tag);
        n_vec++;
        if (int'(op_o) != e_op) begin
            n_fail++;
            $display("FAIL %s op word=%h got=%0d exp=%0d", tag, w, op_o, e_op);
        end
        if (illegal_o != e_bad) begin
            n_fail++;
            $display("FAIL R10 illegal word=%h got=%0b exp=%0b", w, illegal_o, e_bad);
        end
        // R11: full register fields
        if (rd_o != w[11:7] || rs1_o != w[11:7] || rs2_o != w[6:2]) begin
            n_fail++;
            $display("FAIL R11 fields word=%h got=%h/%h/%h exp=%h/%h/%h",
                     w, rd_o, rs1_o, rs2_o, w[11:7], w[11:7], w[6:2]);
        end
        // R12: short fields and their expansion by 8
        if (int'(rs1s_o) != int'(w[9:7]) || int'(rs2s_o) != int'(w[4:2]) ||
            int'(rs1s_x_o) != int'(w[9:7]) + 8 || int'(rs2s_x_o) != int'(w[4:2]) + 8) begin
            n_fail++;
            $display("FAIL R12 short word=%h got=%0d/%0d/%0d/%0d exp=%0d/%0d/%0d/%0d",
                     w, rs1s_o, rs2s_o, rs1s_x_o, rs2s_x_o,
                     w[9:7], w[4:2], int'(w[9:7]) + 8, int'(w[4:2]) + 8);
        end
    endtask

    initial begin
        // Directed corners first.
        apply(16'h0000);   // R3: all-zero word illegal
        apply(16'h0020);   // R3: smallest nonzero wide-add immediate, legal
        apply(16'h9002);   // R9: breakpoint
        apply(16'h9082);   // R9: register call through x1
        apply(16'h9086);   // R9: add
        apply(16'h8082);   // R8: register jump through x1
        apply(16'h8086);   // R8: move
        apply(16'h6101);   // R5: rd = 2 stack adjust
        apply(16'h6181);   // R5: rd = 3 upper immediate
        apply(16'h8C7D);   // R6: and form, bits 6:5 = 11
        apply(16'hFFFF);   // R1: reserved quadrant
        apply(16'h2000);   // R2: floating-point memory form
        apply(16'h2002);   // R7: floating-point memory form
        apply(16'h0001);   // R4: add immediate
        // Full sweep: R1..R12 on every word.
        for (int v = 0; v < 65536; v++) begin
            apply(16'(v));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d vectors, expected completion", n_vec);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule